// File: doc/BRIEF.md
# Replacement-State Probe Sequencer for One Cache Set

This block tests the replacement logic of one set in a set-associative cache that uses least-recently-used replacement. The replacement order inside the cache cannot be read. The sequencer therefore infers it from the hit/miss pattern of a fixed series of reads. Every read targets the same set, and each read uses a distinct tag. The block assumes the set already holds the lines with tag indices 0 to WAYS-1, with index 0 the least recently used and index WAYS-1 the most recent.

After a start pulse the sequencer makes 2*WAYS reads in order. The first read is a fresh line (tag index WAYS), which evicts the oldest line. Next it reads back indices 0 to WAYS-1 in turn, and each of these reads pushes out the next-oldest line. Last it reads indices 1 to WAYS-1 again. These reads must all hit, and they leave the recency order exactly as it was at the start. The sequencer keeps its own recency list of the set. It uses that list to predict each outcome and updates it after every response. Any response that disagrees with the prediction raises a sticky error flag and records the position of the first bad access. Only one read is in flight at a time.

Top module: `lru_probe_seq`

## Requirements
- R1: While reset is low and on the first cycle after it, busy, done, err and rd_req are all 0.
- R2: A start pulse seen while idle makes busy 1 from the next cycle on. Starting also clears done, err and err_idx.
- R3: Read k of a run is issued at base_addr + t*SET_STRIDE. The tag index t runs through this order: WAYS, then 0..WAYS-1, then 1..WAYS-1. A run makes exactly 2*WAYS reads.
- R4: rd_req is a one-cycle pulse. No new rd_req is raised until resp_valid has answered the previous read.
- R5: On a set in the assumed starting state, the first WAYS+1 reads miss and the remaining WAYS-1 reads hit. Any response (resp_hit, 1 = hit) that differs from the prediction sets err.
- R6: err_idx holds the 0-based position of the first mismatching read. Later mismatches in the same run leave err and err_idx unchanged.
- R7: busy drops and done rises in the cycle after the last response. done stays 1, and done and busy are never both 1, until the next start.
- R8: A start pulse while busy is ignored, and the run in progress continues unchanged.
- R9: resp_valid while no read is outstanding is ignored. It changes neither the flags nor the later run.
- R10: A run on a correctly ordered set leaves the set in its starting recency order, so a second run also completes without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a probe run (taken only when idle) |
| base_addr | input | ADDR_W | Address of tag index 0 in the target set, captured at start |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | ADDR_W | Address of the requested read |
| resp_valid | input | 1 | Cache has answered the outstanding read |
| resp_hit | input | 1 | 1 = the answered read hit, 0 = it missed |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run has finished (held until next start) |
| err | output | 1 | Sticky mismatch flag for the last run |
| err_idx | output | STEP_W | Position of the first mismatching read |

## Verification
The bench drives a behavioural LRU set that answers with latencies of 1 to 4 cycles. It begins with the set in the assumed order, and then runs a second time to show that the set was restored. It then starts from two wrong recency orders, which the bench cache shows as mismatches at different read positions. This separates correct state inference from a check that only counts misses. Further runs corrupt selected responses, so the bench can see that err_idx records only the first error. Runs with a stray response while idle and a second start mid-run show that neither input disturbs the address sequence or the flags.

// File: rtl/lru_probe_pkg.sv
// Package: shared types of the replacement-state probe sequencer.
package lru_probe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } probe_state_e;
endpackage

// File: rtl/lru_addr_gen.sv
// lru_addr_gen: maps a step number to the tag index and read address of that
// step. Assumes step < 2*WAYS. The order is: fresh tag WAYS, then 0..WAYS-1,
// then 1..WAYS-1.
module lru_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int WAYS = 3,
    parameter logic [ADDR_W-1:0] SET_STRIDE = 'h100,
    localparam int IDX_W = $clog2(WAYS + 1),
    localparam int STEP_W = $clog2(2 * WAYS)
) (
    input  logic [STEP_W-1:0] step,
    input  logic [ADDR_W-1:0] base,
    output logic [IDX_W-1:0]  tag,
    output logic [ADDR_W-1:0] addr
);
    // Pick the tag index for the current step.
    always_comb begin
        if (step == '0)
            tag = IDX_W'(WAYS);
        else if (int'(step) <= WAYS)
            tag = IDX_W'(int'(step) - 1);
        else
            tag = IDX_W'(int'(step) - WAYS);
    end

    // Form the set-aligned address of that tag.
    assign addr = base + ADDR_W'(tag) * SET_STRIDE;
endmodule

// File: rtl/lru_ref_model.sv
// lru_ref_model: the sequencer's own recency list of the set under test.
// Slot 0 is the least recent line and slot WAYS-1 the most recent. pred_hit
// says whether tag is resident. On upd the tag moves to the most recent slot;
// on a miss the least recent line is dropped. Assumes tags are distinct.
module lru_ref_model #(
    parameter int WAYS = 3,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             upd,
    input  logic [IDX_W-1:0] tag,
    output logic             pred_hit
);
    logic [IDX_W-1:0] order_q [WAYS];
    logic [IDX_W-1:0] order_d [WAYS];
    logic [IDX_W-1:0] pos;

    // Find the slot holding tag; slot 0 stands in on a miss.
    always_comb begin
        pred_hit = 1'b0;
        pos      = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (order_q[i] == tag) begin
                pred_hit = 1'b1;
                pos      = IDX_W'(i);
            end
        end
    end

    // Close the gap at pos and append tag as most recent.
    generate
        for (genvar g = 0; g < WAYS - 1; g++) begin : g_shift
            assign order_d[g] = (IDX_W'(g) >= pos) ? order_q[g+1] : order_q[g];
        end
    endgenerate
    assign order_d[WAYS-1] = tag;

    // Hold the list: assumed start order on reset or init, next order on upd.
    always_ff @(posedge clk) begin
        for (int i = 0; i < WAYS; i++) begin
            if (!rst_n || init)
                order_q[i] <= IDX_W'(i);
            else if (upd)
                order_q[i] <= order_d[i];
        end
    end
endmodule

// File: rtl/lru_probe_ctrl.sv
// lru_probe_ctrl: run control. It issues one read per step, waits for the
// response, compares it with the prediction and keeps the flags. Assumes the
// cache answers every read exactly once.
module lru_probe_ctrl #(
    parameter int WAYS = 3,
    localparam int STEP_W = $clog2(2 * WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              resp_valid,
    input  logic              resp_hit,
    input  logic              pred_hit,
    output logic [STEP_W-1:0] step,
    output logic              model_init,
    output logic              model_upd,
    output logic              rd_req,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [STEP_W-1:0] err_idx
);
    import lru_probe_pkg::*;

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(2 * WAYS - 1);

    probe_state_e state;

    // Decode the handshake and model controls from the state.
    assign rd_req     = (state == ST_ISSUE);
    assign busy       = (state != ST_IDLE);
    assign model_init = (state == ST_IDLE) && start;
    assign model_upd  = (state == ST_WAIT) && resp_valid;

    // Step the run and record the first mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            step    <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
            err_idx <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        step    <= '0;
                        done    <= 1'b0;
                        err     <= 1'b0;
                        err_idx <= '0;
                        state   <= ST_ISSUE;
                    end
                end
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: begin
                    if (resp_valid) begin
                        if ((resp_hit != pred_hit) && !err) begin
                            err     <= 1'b1;
                            err_idx <= step;
                        end
                        if (step == LAST_STEP) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            step  <= step + 1'b1;
                            state <= ST_ISSUE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lru_probe_seq.sv
// lru_probe_seq: top of the replacement-state probe sequencer. It reads one
// cache set through an eviction and probe series and flags any hit/miss
// that disagrees with the assumed LRU order. Assumes the set starts with
// tags 0..WAYS-1, tag 0 least recent.
module lru_probe_seq #(
    parameter int ADDR_W = 32,
    parameter int WAYS = 3,
    parameter logic [ADDR_W-1:0] SET_STRIDE = 'h100,
    localparam int IDX_W = $clog2(WAYS + 1),
    localparam int STEP_W = $clog2(2 * WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              resp_valid,
    input  logic              resp_hit,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [STEP_W-1:0] err_idx
);
    logic [ADDR_W-1:0] base_q;
    logic [STEP_W-1:0] step;
    logic [IDX_W-1:0]  cur_tag;
    logic              pred_hit;
    logic              model_init;
    logic              model_upd;

    // Capture the set base when a run is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else if (model_init)
            base_q <= base_addr;
    end

    lru_addr_gen #(
        .ADDR_W(ADDR_W), .WAYS(WAYS), .SET_STRIDE(SET_STRIDE)
    ) u_addr (
        .step(step), .base(base_q), .tag(cur_tag), .addr(rd_addr)
    );

    lru_ref_model #(.WAYS(WAYS), .IDX_W(IDX_W)) u_model (
        .clk(clk), .rst_n(rst_n), .init(model_init), .upd(model_upd),
        .tag(cur_tag), .pred_hit(pred_hit)
    );

    lru_probe_ctrl #(.WAYS(WAYS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .pred_hit(pred_hit),
        .step(step), .model_init(model_init), .model_upd(model_upd),
        .rd_req(rd_req), .busy(busy), .done(done), .err(err),
        .err_idx(err_idx)
    );
endmodule

// File: rtl/lru_probe_seq_chk.sv
// lru_probe_seq_chk: protocol and flag assertions for lru_probe_seq.
// Assumes base_addr is held steady during a run.
module lru_probe_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int STEP_W = 3,
    parameter logic [ADDR_W-1:0] SET_STRIDE = 'h100
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] base_addr,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              resp_valid,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [STEP_W-1:0] err_idx
);
    logic outstanding;

    // Track whether a read is waiting for its response.
    always_ff @(posedge clk) begin
        if (!rst_n)
            outstanding <= 1'b0;
        else if (rd_req)
            outstanding <= 1'b1;
        else if (resp_valid)
            outstanding <= 1'b0;
    end

    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!busy && !done && !err && !rd_req));

    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r3_set_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (((rd_addr - base_addr) % SET_STRIDE) == '0));

    a_r4_one_cycle_req: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    a_r4_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding |-> !rd_req);

    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && busy) |=> (err && $stable(err_idx)));

    a_r7_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind lru_probe_seq lru_probe_seq_chk #(
    .ADDR_W(ADDR_W), .STEP_W(STEP_W), .SET_STRIDE(SET_STRIDE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .rd_req(rd_req), .rd_addr(rd_addr), .resp_valid(resp_valid),
    .busy(busy), .done(done), .err(err), .err_idx(err_idx)
);

// File: tb/lru_probe_seq_bench.sv
`timescale 1ns/1ps
module lru_probe_seq_bench;
    localparam int ADDR_W = 32;
    localparam int WAYS = 3;
    localparam int STEP_W = $clog2(2 * WAYS);
    localparam logic [31:0] STRIDE = 32'h100;
    localparam logic [31:0] BASE = 32'h4000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [ADDR_W-1:0] base_addr = BASE;
    logic rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic resp_valid = 1'b0;
    logic resp_hit = 1'b0;
    logic busy, done, err;
    logic [STEP_W-1:0] err_idx;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;

    // Behavioural cache set (front = least recent) and run bookkeeping.
    int cq[$];
    int exp_q[$];
    int lat = 1;
    int cnt = 0;
    int flip_mask = 0;
    int acc_n = 0;
    int first_bad = -1;
    bit outst = 1'b0;
    bit pend_hit = 1'b0;
    bit inject_stray = 1'b0;

    always #2 clk = ~clk;

    lru_probe_seq #(.ADDR_W(ADDR_W), .WAYS(WAYS), .SET_STRIDE(STRIDE)) u_lru_probe_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .rd_req(rd_req), .rd_addr(rd_addr), .resp_valid(resp_valid),
        .resp_hit(resp_hit), .busy(busy), .done(done), .err(err),
        .err_idx(err_idx)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit cache_access(input int t);
        bit h = 1'b0;
        for (int i = 0; i < cq.size(); i++) begin
            if (cq[i] == t) begin
                h = 1'b1;
                cq.delete(i);
                break;
            end
        end
        if (!h && cq.size() == WAYS) void'(cq.pop_front());
        cq.push_back(t);
        return h;
    endfunction

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: got %0d expected %0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // Cache responder and per-clock protocol comparison, on falling edges.
    initial begin
        forever begin
            @(negedge clk);
            resp_valid = 1'b0;
            if (inject_stray) begin
                resp_valid   = 1'b1;
                resp_hit     = 1'b1;
                inject_stray = 1'b0;
            end
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    resp_valid = 1'b1;
                    resp_hit   = pend_hit;
                    outst      = 1'b0;
                end
            end
            if (rd_req) begin
                int t;
                int et;
                bit h;
                bit pat;
                check(!outst, "R4", "request while outstanding", 1, 0);
                et = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
                check(rd_addr == BASE + et * STRIDE, "R3", "read address",
                      rd_addr, BASE + et * STRIDE);
                t = int'((rd_addr - BASE) / STRIDE);
                h = cache_access(t) ^ flip_mask[acc_n];
                pat = (acc_n >= WAYS + 1);
                if (h != pat && first_bad < 0) first_bad = acc_n;
                acc_n++;
                pend_hit = h;
                outst = 1'b1;
                cnt = lat;
            end
        end
    end

    task automatic run_probe(input int l, input int fmask, input int mid_start,
                             input bit first_err_only);
        int t = 0;
        lat = l;
        flip_mask = fmask;
        acc_n = 0;
        first_bad = -1;
        exp_q = {};
        exp_q.push_back(WAYS);
        for (int i = 0; i < WAYS; i++) exp_q.push_back(i);
        for (int i = 1; i < WAYS; i++) exp_q.push_back(i);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2", "busy after start", busy, 1);
        check(done == 1'b0, "R2", "done cleared by start", done, 0);
        if (mid_start > 0) begin
            repeat (mid_start) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(busy == 1'b1, "R8", "start while busy ignored", busy, 1);
        end
        while (!done && t < 5000) begin
            @(negedge clk);
            t++;
        end
        check(t < 5000, "R7", "run completes", t, 0);
        check(busy == 1'b0 && done == 1'b1, "R7", "idle with done", {busy, done}, 1);
        check(acc_n == 2 * WAYS, "R3", "read count", acc_n, 2 * WAYS);
        check(err == (first_bad >= 0), "R5", "error flag", err, first_bad >= 0);
        if (first_bad >= 0)
            check(err_idx == first_bad, first_err_only ? "R6" : "R5",
                  "first mismatch index", err_idx, first_bad);
        repeat (3) @(negedge clk);
        check(done == 1'b1 && busy == 1'b0, "R7", "done held", done, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !err && !rd_req, "R1", "outputs in reset",
              {busy, done, err, rd_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !err && !rd_req, "R1", "outputs after reset",
              {busy, done, err, rd_req}, 0);

        // R5: correctly ordered set, unit latency.
        cq = '{0, 1, 2};
        run_probe(1, 0, 0, 1'b0);
        // R10: set restored, so a second run is clean.
        check(cq.size() == 3 && cq[0] == 0 && cq[1] == 1 && cq[2] == 2,
              "R10", "set order restored", cq[0], 0);
        run_probe(3, 0, 0, 1'b0);
        check(err == 1'b0, "R10", "second run clean", err, 0);

        // R9: stray response while idle changes nothing.
        @(negedge clk);
        inject_stray = 1'b1;
        repeat (3) @(negedge clk);
        check(done == 1'b1 && err == 1'b0 && busy == 1'b0, "R9", "flags after stray",
              {busy, done, err}, 2);
        run_probe(2, 0, 0, 1'b0);
        check(err == 1'b0, "R9", "run after stray clean", err, 0);

        // R6: corrupted responses at reads 4 and 5, only the first recorded.
        cq = '{0, 1, 2};
        run_probe(1, 'b110000, 0, 1'b1);
        check(err_idx == 4, "R6", "first corrupted read", err_idx, 4);

        // R5: wrong starting orders show up at different reads.
        cq = '{1, 0, 2};
        run_probe(2, 0, 0, 1'b0);
        check(err_idx == 1, "R5", "order 1,0,2 mismatch", err_idx, 1);
        cq = '{0, 2, 1};
        run_probe(1, 0, 0, 1'b0);
        check(err_idx == 2, "R5", "order 0,2,1 mismatch", err_idx, 2);

        // R8: start pulsed mid-run does not restart the sequence.
        cq = '{0, 1, 2};
        run_probe(4, 0, 5, 1'b0);
        check(err == 1'b0, "R8", "run unaffected by extra start", err, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule